// File: doc/BRIEF.md
# UART FIFO Mode and Depth Controller

This block is the per-channel mode logic of a 16550-family serial port. It stores the FIFO control bits, the line control register and the enhanced feature register. It also guards the one FIFO control bit that widens the FIFO. From these bits and an external FIFO-select strap it works out the compatibility personality of the channel. That personality sets the usable depth of the channel's two byte FIFOs: 1, 16 or 128 entries.

The transmit and receive FIFOs sit inside the block. Each has a push port, a pop port with show-ahead data, and full and empty flags. The full flag follows the depth currently in force. Whenever that depth changes, both FIFOs are emptied. The block exports the mode and depth as status. It also exports one enable that tells the external flow-control logic whether legacy automatic RTS/CTS handling may run.

Top module: `uart_fifo_mode_ctrl`

## Requirements
- R1: After reset the FIFO enable bit and the extension bit are 0, LCR and EFR read 0, `mode_o` is 0, `depth_o` is 1, both FIFOs are empty and `legacy_afc_en_o` is 1.
- R2: While the FIFO enable bit (FCR bit 0) is 0, `mode_o` is 0 and `depth_o` is 1, whatever EFR bit 4, FCR bit 5 and `fifo_sel_i` hold.
- R3: With FCR bit 0 = 1, EFR bit 4 = 0, FCR bit 5 = 0 and `fifo_sel_i` = 0, `mode_o` is 1 and `depth_o` is 16.
- R4: With FCR bit 0 = 1, EFR bit 4 = 0 and `fifo_sel_i` = 1, `mode_o` is 2 and `depth_o` is 128, whatever FCR bit 5 holds.
- R5: With FCR bit 0 = 1, EFR bit 4 = 0, `fifo_sel_i` = 0 and FCR bit 5 = 1, `mode_o` is 3 and `depth_o` is 128.
- R6: With FCR bit 0 = 1 and EFR bit 4 = 1, `mode_o` is 4 and `depth_o` is 128, whatever `fifo_sel_i` and FCR bit 5 hold.
- R7: An FCR write updates FCR bit 5 only if LCR bit 7 is 1 at that write. Otherwise bit 5 keeps its old value, and FCR bit 0 is still written.
- R8: `legacy_afc_en_o` is 1 exactly when EFR bit 4 is 0.
- R9: Each FIFO raises full when its occupancy equals `depth_o`. A push while full is dropped. Data leaves in the order it entered.
- R10: Any change of the effective depth empties both FIFOs in the next clock cycle. Pushes and pops in that cycle are discarded.
- R11: `reg_sel_i` selects the register: 0 = FCR, 1 = LCR, 2 = EFR. Writes take effect at the clock edge that samples `reg_wr_i`. Reads of LCR and EFR return the stored byte. Reads of FCR and of select 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_sel_i | input | 1 | FIFO-select strap |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| tx_push_i | input | 1 | Transmit FIFO push |
| tx_data_i | input | DW | Transmit push data |
| tx_pop_i | input | 1 | Transmit FIFO pop |
| tx_data_o | output | DW | Transmit head entry |
| tx_full_o | output | 1 | Transmit FIFO full |
| tx_empty_o | output | 1 | Transmit FIFO empty |
| rx_push_i | input | 1 | Receive FIFO push |
| rx_data_i | input | DW | Receive push data |
| rx_pop_i | input | 1 | Receive FIFO pop |
| rx_data_o | output | DW | Receive head entry |
| rx_full_o | output | 1 | Receive FIFO full |
| rx_empty_o | output | 1 | Receive FIFO empty |
| mode_o | output | 3 | 0=byte, 1=550, 2=ext 550, 3=750, 4=650/950 |
| depth_o | output | CW | Effective FIFO depth |
| legacy_afc_en_o | output | 1 | Legacy auto flow control allowed |

## Verification
The assertions check a few rules on every cycle. Occupancy never exceeds the depth in force. A push into a full FIFO leaves the count unchanged. A depth change empties both FIFOs one cycle later. An FCR write with the guard bit clear leaves the extension bit unchanged. The priority among the FIFO enable bit, the enhanced bit, the strap and the extension bit can only be shown by the bench's scenarios. The same holds for the stickiness of the extension bit across later writes, and for FIFO ordering and the exact full thresholds.

// File: rtl/uart_fifo_mode_ctrl.sv
module uart_fifo_mode_ctrl #(
  parameter int DW        = 8,
  parameter int MAX_DEPTH = 128,
  parameter int MID_DEPTH = 16,
  localparam int AW = $clog2(MAX_DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_sel_i,
  input  logic          reg_wr_i,
  input  logic [1:0]    reg_sel_i,
  input  logic [7:0]    reg_wdata_i,
  output logic [7:0]    reg_rdata_o,
  input  logic          tx_push_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          tx_pop_i,
  output logic [DW-1:0] tx_data_o,
  output logic          tx_full_o,
  output logic          tx_empty_o,
  input  logic          rx_push_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_pop_i,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_full_o,
  output logic          rx_empty_o,
  output logic [2:0]    mode_o,
  output logic [CW-1:0] depth_o,
  output logic          legacy_afc_en_o
);
  localparam logic [CW-1:0] D_BYTE = CW'(1);
  localparam logic [CW-1:0] D_MID  = CW'(MID_DEPTH);
  localparam logic [CW-1:0] D_MAX  = CW'(MAX_DEPTH);

  logic       fifo_en, ext_bit;
  logic [7:0] lcr, efr;
  logic [CW-1:0] depth_q;
  logic       flush;

  wire wr_fcr = reg_wr_i && reg_sel_i == 2'd0;
  wire wr_lcr = reg_wr_i && reg_sel_i == 2'd1;
  wire wr_efr = reg_wr_i && reg_sel_i == 2'd2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en <= 1'b0;
      ext_bit <= 1'b0;
      lcr     <= '0;
      efr     <= '0;
    end else begin
      if (wr_fcr) begin
        fifo_en <= reg_wdata_i[0];
        if (lcr[7]) ext_bit <= reg_wdata_i[5];
      end
      if (wr_lcr) lcr <= reg_wdata_i;
      if (wr_efr) efr <= reg_wdata_i;
    end
  end

  always_comb begin
    case (reg_sel_i)
      2'd1:    reg_rdata_o = lcr;
      2'd2:    reg_rdata_o = efr;
      default: reg_rdata_o = '0;
    endcase
  end

  always_comb begin
    if (!fifo_en)        begin mode_o = 3'd0; depth_o = D_BYTE; end
    else if (efr[4])     begin mode_o = 3'd4; depth_o = D_MAX;  end
    else if (fifo_sel_i) begin mode_o = 3'd2; depth_o = D_MAX;  end
    else if (ext_bit)    begin mode_o = 3'd3; depth_o = D_MAX;  end
    else                 begin mode_o = 3'd1; depth_o = D_MID;  end
  end

  assign legacy_afc_en_o = !efr[4];
  assign flush = depth_o != depth_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) depth_q <= D_BYTE;
    else        depth_q <= depth_o;
  end

  // R7
  guard_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fcr && !lcr[7]) |=> $stable(ext_bit));

  logic [1:0]    push_v, pop_v, full_v, empty_v;
  logic [DW-1:0] din_v [2];
  logic [DW-1:0] dout_v [2];

  assign push_v   = {rx_push_i, tx_push_i};
  assign pop_v    = {rx_pop_i, tx_pop_i};
  assign din_v[0] = tx_data_i;
  assign din_v[1] = rx_data_i;

  for (genvar g = 0; g < 2; g++) begin : g_fifo
    logic [DW-1:0] mem [MAX_DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    wire do_push = push_v[g] && !full_v[g] && !flush;
    wire do_pop  = pop_v[g] && !empty_v[g] && !flush;

    assign full_v[g]  = cnt >= depth_o;
    assign empty_v[g] = cnt == '0;
    assign dout_v[g]  = mem[rp];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wp <= '0; rp <= '0; cnt <= '0;
      end else if (flush) begin
        wp <= '0; rp <= '0; cnt <= '0;
      end else begin
        if (do_push) wp <= wp + 1'b1;
        if (do_pop)  rp <= rp + 1'b1;
        cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
    end

    always_ff @(posedge clk) if (do_push) mem[wp] <= din_v[g];

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= depth_q);
    // R9
    drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full_v[g] && push_v[g] && !pop_v[g] && !flush) |=> cnt == $past(cnt));
    // R10
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> cnt == '0);
  end

  assign tx_full_o  = full_v[0];
  assign tx_empty_o = empty_v[0];
  assign tx_data_o  = dout_v[0];
  assign rx_full_o  = full_v[1];
  assign rx_empty_o = empty_v[1];
  assign rx_data_o  = dout_v[1];
endmodule

// File: tb/uart_fifo_mode_ctrl_tb.sv
module uart_fifo_mode_ctrl_tb;
  logic clk = 0, rst_n = 0;
  always #5ns clk = ~clk;

  logic fifo_sel = 0, reg_wr = 0;
  logic [1:0] reg_sel = 0;
  logic [7:0] wdata = 0, rdata;
  logic tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
  logic [7:0] tx_din = 0, rx_din = 0, tx_q, rx_q;
  logic tx_full, tx_empty, rx_full, rx_empty, afc;
  logic [2:0] mode;
  logic [7:0] depth;
  int checks = 0, fails = 0;

  uart_fifo_mode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_sel_i(fifo_sel),
    .reg_wr_i(reg_wr), .reg_sel_i(reg_sel), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .tx_push_i(tx_push), .tx_data_i(tx_din), .tx_pop_i(tx_pop), .tx_data_o(tx_q),
    .tx_full_o(tx_full), .tx_empty_o(tx_empty),
    .rx_push_i(rx_push), .rx_data_i(rx_din), .rx_pop_i(rx_pop), .rx_data_o(rx_q),
    .rx_full_o(rx_full), .rx_empty_o(rx_empty),
    .mode_o(mode), .depth_o(depth), .legacy_afc_en_o(afc));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); reg_sel = s; wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk); reg_sel = s; #1; d = rdata;
  endtask

  task automatic push_tx(input logic [7:0] d);
    @(negedge clk); tx_push = 1; tx_din = d;
    @(negedge clk); tx_push = 0;
  endtask

  task automatic pop_tx();
    @(negedge clk); tx_pop = 1;
    @(negedge clk); tx_pop = 0;
  endtask

  // {lcr7, fcr, efr, fifo_sel, mode, depth}
  localparam logic [28:0] VEC [10] = '{
    {1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 8'd1},
    {1'b0, 8'h01, 8'h00, 1'b0, 3'd1, 8'd16},
    {1'b0, 8'h01, 8'h00, 1'b1, 3'd2, 8'd128},
    {1'b0, 8'h21, 8'h00, 1'b0, 3'd1, 8'd16},
    {1'b1, 8'h21, 8'h00, 1'b0, 3'd3, 8'd128},
    {1'b1, 8'h21, 8'h00, 1'b1, 3'd2, 8'd128},
    {1'b0, 8'h01, 8'h10, 1'b0, 3'd4, 8'd128},
    {1'b0, 8'h00, 8'h10, 1'b1, 3'd0, 8'd1},
    {1'b1, 8'h01, 8'h10, 1'b1, 3'd4, 8'd128},
    {1'b0, 8'h01, 8'h00, 1'b0, 3'd1, 8'd16}
  };

  initial begin
    #2_000_000ns;
    fails++; checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state
    chk("R1 mode", mode, 0);
    chk("R1 depth", depth, 1);
    chk("R1 empty", {tx_empty, rx_empty}, 3);
    chk("R1 afc", afc, 1);
    rd(2'd1, r); chk("R1 lcr", r, 0);
    rd(2'd2, r); chk("R1 efr", r, 0);

    // R2 R3 R4 R5 R6 R7 R8 priority table
    foreach (VEC[i]) begin
      logic [28:0] v = VEC[i];
      wr(2'd1, {v[28], 7'd0});
      wr(2'd0, v[27:20]);
      wr(2'd1, 8'h00);
      wr(2'd2, v[19:12]);
      @(negedge clk); fifo_sel = v[11];
      tick();
      chk($sformatf("R2-R7 vec%0d mode", i), mode, int'(v[10:8]));
      chk($sformatf("R2-R7 vec%0d depth", i), depth, int'(v[7:0]));
      chk($sformatf("R8 vec%0d afc", i), afc, int'(!v[16]));
    end

    // R11 readback
    wr(2'd1, 8'h5A); rd(2'd1, r); chk("R11 lcr", r, 8'h5A);
    wr(2'd2, 8'h3C); rd(2'd2, r); chk("R11 efr", r, 8'h3C);
    rd(2'd0, r); chk("R11 fcr reads 0", r, 0);
    rd(2'd3, r); chk("R11 sel3 reads 0", r, 0);
    wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    @(negedge clk); fifo_sel = 0;
    wr(2'd0, 8'h01); tick();
    chk("R3 depth 16", depth, 16);

    // R9 fill 16, overflow dropped, order kept
    for (int k = 0; k < 17; k++) push_tx(8'(k + 8'h40));
    chk("R9 full at 16", tx_full, 1);
    for (int k = 0; k < 16; k++) begin
      if (k == 0 || k == 15) chk("R9 order", tx_q, k + 8'h40);
      pop_tx();
    end
    chk("R9 extra push dropped", tx_empty, 1);

    // R10 flush on depth change
    push_tx(8'h11);
    @(negedge clk); rx_push = 1; rx_din = 8'h22;
    @(negedge clk); rx_push = 0;
    chk("R10 pre tx", tx_empty, 0);
    chk("R10 pre rx", rx_empty, 0);
    @(negedge clk); fifo_sel = 1;
    tick();
    chk("R10 depth", depth, 128);
    chk("R10 tx flushed", tx_empty, 1);
    chk("R10 rx flushed", rx_empty, 1);

    // R9 128 fill
    for (int k = 0; k < 128; k++) begin
      if (k == 127) chk("R9 not full at 127", tx_full, 0);
      push_tx(8'(k));
    end
    chk("R9 full at 128", tx_full, 1);

    // R2 R9 byte mode depth 1
    wr(2'd0, 8'h00); tick();
    chk("R2 depth 1", depth, 1);
    push_tx(8'hA5);
    chk("R9 byte full", tx_full, 1);
    push_tx(8'h5A);
    chk("R9 byte head", tx_q, 8'hA5);
    pop_tx();
    chk("R9 byte drop", tx_empty, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule